// File: doc/BRIEF.md
# Flag-Tagged Dual-Half Word Link

This block moves a wide parallel word across a link path half as wide. The transmit side takes one word per word period and sends it as two half-width frames on consecutive cycles: first the lower half, then the upper. A side-band tag bit goes with each frame and names the half on the bus. The receive side uses that tag to steer each frame into its own register. It stages the lower half until the matching upper half arrives, then presents the whole word at once with a one-cycle valid pulse.

A single fast clock runs at the half-frame rate. A word-rate strobe takes the place of dual-edge clocking. Out-of-order tags are caught by the receiver: it drops the partial word, raises a sticky error and waits for the next lower half before it accepts data again. The two sides have separate ports, so they can run as a loopback or on different link ends.

Top module: `dfl_link`

## Requirements
- R1: While `rst_ni` is low, `tx_half_o`, `tx_flag_o`, `tx_half_vld_o`, `rx_word_o`, `rx_word_vld_o` and `rx_seq_err_o` are all zero.
- R2: A clock edge with `tx_word_stb_i`=1 captures `tx_word_i`. After that edge, `tx_half_o` holds bits [HALF_W-1:0], `tx_flag_o`=0 (lower) and `tx_half_vld_o`=1.
- R3: After the next edge, if no new strobe arrives, `tx_half_o` holds bits [2*HALF_W-1:HALF_W] of the captured word and `tx_flag_o`=1 (upper), with `tx_half_vld_o`=1. A change on `tx_word_i` after the capture edge does not affect this frame.
- R4: After an edge where there is neither a strobe nor a pending upper half, `tx_half_vld_o` is 0.
- R5: The receiver stores a half with `rx_flag_i`=0. After the edge that accepts the following half with `rx_flag_i`=1, `rx_word_o` = {upper, lower} and `rx_word_vld_o`=1.
- R6: `rx_word_vld_o` is high for exactly one cycle per assembled word. `rx_word_o` keeps its value until the next word is assembled.
- R7: Cycles with `rx_half_vld_i`=0 are ignored. The receiver state and outputs are unchanged, so idle cycles between a lower and an upper half still yield the correct word.
- R8: Two valid halves in a row with the same tag set `rx_seq_err_o`, which stays set until reset. The pending lower half is dropped and no word is produced. Assembly restarts only with the next half tagged 0.
- R9: If the first valid half after reset carries tag 1, `rx_seq_err_o` is set and no word is produced.
- R10: With a strobe on every second cycle, the transmitter sends halves with no gap. In loopback, one word comes out every two cycles, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Half-frame rate clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tx_word_i | input | 2*HALF_W | Word to transmit |
| tx_word_stb_i | input | 1 | Word-rate strobe, captures tx_word_i |
| tx_half_o | output | HALF_W | Outgoing half frame |
| tx_flag_o | output | 1 | Tag of outgoing half: 0 lower, 1 upper |
| tx_half_vld_o | output | 1 | Outgoing half is valid |
| rx_half_i | input | HALF_W | Incoming half frame |
| rx_flag_i | input | 1 | Tag of incoming half: 0 lower, 1 upper |
| rx_half_vld_i | input | 1 | Incoming half is valid |
| rx_word_o | output | 2*HALF_W | Reassembled word |
| rx_word_vld_o | output | 1 | One-cycle pulse when a word is assembled |
| rx_seq_err_o | output | 1 | Sticky tag-sequence error |

## Verification
The bench builds the block with the default HALF_W of 20, so each word is 40 bits wide. With this width, the bench can use halves that differ in every bit (all ones against all zeros, and alternating patterns). A half swapped, shifted or taken from the wrong register therefore always shows up in the reassembled word. In loopback, the bench feeds the transmitter straight into the receiver. It can also drive the receiver directly, and so reaches tag orders that the transmitter never makes: duplicated lower halves, a leading upper half and idle gaps.

// File: rtl/dfl_pkg.sv
package dfl_pkg;
  parameter int unsigned DFL_HALF_W = 20;

  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_tag_e;
endpackage

// File: rtl/dfl_tx.sv
module dfl_tx
  import dfl_pkg::*;
#(
  parameter int unsigned HALF_W = DFL_HALF_W,
  localparam int unsigned WORD_W = 2 * HALF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] word_i,
  input  logic              word_stb_i,
  output logic [HALF_W-1:0] half_o,
  output logic              flag_o,
  output logic              half_vld_o
);
  logic [HALF_W-1:0] hi_hold_q;
  logic              hi_pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_hold_q  <= '0;
      hi_pend_q  <= 1'b0;
      half_o     <= '0;
      flag_o     <= HALF_LO;
      half_vld_o <= 1'b0;
    end else if (word_stb_i) begin
      // strobe phase 0: lower half goes out, upper waits
      hi_hold_q  <= word_i[WORD_W-1:HALF_W];
      hi_pend_q  <= 1'b1;
      half_o     <= word_i[HALF_W-1:0];
      flag_o     <= HALF_LO;
      half_vld_o <= 1'b1;
    end else if (hi_pend_q) begin
      hi_pend_q  <= 1'b0;
      half_o     <= hi_hold_q;
      flag_o     <= HALF_HI;
      half_vld_o <= 1'b1;
    end else begin
      half_vld_o <= 1'b0;
    end
  end

  AST_TX_HI_AFTER_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (half_vld_o && flag_o) |-> ($past(half_vld_o) && !$past(flag_o))) // R3
    else $error("upper half without preceding lower half");

  AST_TX_LO_THEN_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (half_vld_o && !flag_o && !word_stb_i) |=> (half_vld_o && flag_o)) // R3
    else $error("lower half not followed by upper half");

  AST_TX_STB_LOADS_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_stb_i |=> (half_vld_o && !flag_o)) // R2
    else $error("strobe did not emit lower half");
endmodule

// File: rtl/dfl_rx.sv
module dfl_rx
  import dfl_pkg::*;
#(
  parameter int unsigned HALF_W = DFL_HALF_W,
  localparam int unsigned WORD_W = 2 * HALF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [HALF_W-1:0] half_i,
  input  logic              flag_i,
  input  logic              half_vld_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_vld_o,
  output logic              seq_err_o
);
  logic [HALF_W-1:0] lo_q;
  half_tag_e         exp_q;
  logic              tag_ok;

  assign tag_ok = (flag_i == exp_q);

  // tag-steered capture; exp_q tracks which half is due next
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q       <= '0;
      exp_q      <= HALF_LO;
      word_o     <= '0;
      word_vld_o <= 1'b0;
      seq_err_o  <= 1'b0;
    end else begin
      word_vld_o <= 1'b0;
      if (half_vld_i) begin
        if (!tag_ok) begin
          exp_q     <= HALF_LO;
          seq_err_o <= 1'b1;
        end else if (exp_q == HALF_LO) begin
          lo_q  <= half_i;
          exp_q <= HALF_HI;
        end else begin
          // staged lower half leaves together with the upper half
          word_o     <= {half_i, lo_q};
          word_vld_o <= 1'b1;
          exp_q      <= HALF_LO;
        end
      end
    end
  end

  AST_RX_VLD_NEEDS_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(word_vld_o) |-> ($past(half_vld_i) && $past(flag_i))) // R5
    else $error("word valid without an upper half");

  AST_RX_VLD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld_o |=> !word_vld_o) // R6
    else $error("word valid longer than one cycle");

  AST_RX_WORD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_vld_o |-> $stable(word_o)) // R6
    else $error("word output changed without valid");

  AST_RX_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_err_o |=> seq_err_o) // R8
    else $error("sequence error cleared without reset");

  AST_RX_IDLE_NO_VLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !half_vld_i |=> !word_vld_o) // R7
    else $error("word produced on idle cycle");
endmodule

// File: rtl/dfl_link.sv
module dfl_link
  import dfl_pkg::*;
#(
  parameter int unsigned HALF_W = DFL_HALF_W,
  localparam int unsigned WORD_W = 2 * HALF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] tx_word_i,
  input  logic              tx_word_stb_i,
  output logic [HALF_W-1:0] tx_half_o,
  output logic              tx_flag_o,
  output logic              tx_half_vld_o,
  input  logic [HALF_W-1:0] rx_half_i,
  input  logic              rx_flag_i,
  input  logic              rx_half_vld_i,
  output logic [WORD_W-1:0] rx_word_o,
  output logic              rx_word_vld_o,
  output logic              rx_seq_err_o
);
  dfl_tx #(.HALF_W(HALF_W)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .word_i     (tx_word_i),
    .word_stb_i (tx_word_stb_i),
    .half_o     (tx_half_o),
    .flag_o     (tx_flag_o),
    .half_vld_o (tx_half_vld_o)
  );

  dfl_rx #(.HALF_W(HALF_W)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .half_i     (rx_half_i),
    .flag_i     (rx_flag_i),
    .half_vld_i (rx_half_vld_i),
    .word_o     (rx_word_o),
    .word_vld_o (rx_word_vld_o),
    .seq_err_o  (rx_seq_err_o)
  );
endmodule

// File: tb/tb_dfl_link.sv
module tb_dfl_link;
  localparam int HW = 20;
  localparam int WW = 2 * HW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [WW-1:0] tx_word = '0;
  logic          tx_stb = 1'b0;
  logic [HW-1:0] tx_half;
  logic          tx_flag, tx_hv;
  logic          inj = 1'b0;
  logic [HW-1:0] inj_half = '0;
  logic          inj_flag = 1'b0, inj_hv = 1'b0;
  logic [HW-1:0] rx_half;
  logic          rx_flag, rx_hv;
  logic [WW-1:0] rx_word;
  logic          rx_vld, rx_err;

  assign rx_half = inj ? inj_half : tx_half;
  assign rx_flag = inj ? inj_flag : tx_flag;
  assign rx_hv   = inj ? inj_hv   : tx_hv;

  dfl_link #(.HALF_W(HW)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .tx_word_i(tx_word), .tx_word_stb_i(tx_stb),
    .tx_half_o(tx_half), .tx_flag_o(tx_flag), .tx_half_vld_o(tx_hv),
    .rx_half_i(rx_half), .rx_flag_i(rx_flag), .rx_half_vld_i(rx_hv),
    .rx_word_o(rx_word), .rx_word_vld_o(rx_vld), .rx_seq_err_o(rx_err)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; inj = 1'b0; inj_hv = 1'b0; tx_stb = 1'b0;
    @(negedge clk);
    chk("R1 tx_half", 64'(tx_half), 64'(0));
    chk("R1 tx_flag/vld", 64'({tx_flag, tx_hv}), 64'(0));
    chk("R1 rx_word", 64'(rx_word), 64'(0));
    chk("R1 rx_vld/err", 64'({rx_vld, rx_err}), 64'(0));
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // single word in loopback, input word changes after capture
  task automatic t_single(input logic [WW-1:0] w);
    tx_word = w; tx_stb = 1'b1;
    @(negedge clk); tx_stb = 1'b0; tx_word = ~w;
    chk("R2 lower half", 64'(tx_half), 64'(w[HW-1:0]));
    chk("R2 flag/vld", 64'({tx_flag, tx_hv}), 64'(2'b01));
    @(negedge clk);
    chk("R3 upper half", 64'(tx_half), 64'(w[WW-1:HW]));
    chk("R3 flag/vld", 64'({tx_flag, tx_hv}), 64'(2'b11));
    @(negedge clk);
    chk("R4 tx idle", 64'(tx_hv), 64'(0));
    chk("R5 rx word", 64'(rx_word), 64'(w));
    chk("R5 rx vld", 64'(rx_vld), 64'(1));
    @(negedge clk);
    chk("R6 vld pulse", 64'(rx_vld), 64'(0));
    chk("R6 word hold", 64'(rx_word), 64'(w));
  endtask

  task automatic t_stream();
    logic [WW-1:0] ws [3];
    ws[0] = 40'hFFFFF_00000; ws[1] = 40'h00000_FFFFF; ws[2] = 40'hAAAAA_55555;
    for (int i = 0; i < 3; i++) begin
      tx_word = ws[i]; tx_stb = 1'b1;
      @(negedge clk); tx_stb = 1'b0;
      chk("R10 tx lower", 64'({tx_flag, tx_hv, tx_half}), 64'({2'b01, ws[i][HW-1:0]}));
      if (i > 0) chk("R10 rx word", 64'({rx_vld, rx_word}), 64'({1'b1, ws[i-1]}));
      @(negedge clk);
      chk("R10 tx upper", 64'({tx_flag, tx_hv, tx_half}), 64'({2'b11, ws[i][WW-1:HW]}));
    end
    @(negedge clk);
    chk("R10 rx last", 64'({rx_vld, rx_word}), 64'({1'b1, ws[2]}));
  endtask

  task automatic inj_half_f(input logic f, input logic [HW-1:0] d);
    inj_hv = 1'b1; inj_flag = f; inj_half = d;
    @(negedge clk); inj_hv = 1'b0;
  endtask

  task automatic t_idle_gap();
    inj = 1'b1;
    inj_half_f(1'b0, 20'h12345);
    inj_half = 20'hBAD00; inj_flag = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R7 idle no vld", 64'(rx_vld), 64'(0));
    inj_half_f(1'b1, 20'h6789A);
    chk("R7 word after gap", 64'({rx_vld, rx_word}), 64'({1'b1, 40'h6789A_12345}));
    chk("R7 no err", 64'(rx_err), 64'(0));
    inj = 1'b0;
  endtask

  task automatic t_dup_lo();
    inj = 1'b1;
    inj_half_f(1'b0, 20'h11111);
    inj_half_f(1'b0, 20'h22222);
    chk("R8 err set", 64'(rx_err), 64'(1));
    chk("R8 no vld", 64'(rx_vld), 64'(0));
    inj_half_f(1'b1, 20'h33333);
    chk("R8 upper dropped", 64'(rx_vld), 64'(0));
    inj_half_f(1'b0, 20'h44444);
    inj_half_f(1'b1, 20'h55555);
    chk("R8 resync word", 64'({rx_vld, rx_word}), 64'({1'b1, 40'h55555_44444}));
    chk("R8 err sticky", 64'(rx_err), 64'(1));
    inj = 1'b0;
  endtask

  task automatic t_first_hi();
    inj = 1'b1;
    inj_half_f(1'b1, 20'h0F0F0);
    chk("R9 err on leading upper", 64'(rx_err), 64'(1));
    chk("R9 no vld", 64'(rx_vld), 64'(0));
    inj = 1'b0;
  endtask

  initial begin
    fork
      begin
        do_reset();
        t_single(40'hFFFFF_00000);
        t_single(40'h5A5A5_A5A5A);
        t_stream();
        do_reset();
        t_idle_gap();
        t_dup_lo();
        do_reset();
        t_first_hi();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule